// File: doc/BRIEF.md
# SDRAM Burst Sequencer with Automatic Row Crossing

This block turns one linear burst request into single-data-rate SDRAM commands. A requester gives a start row, a start column, a beat count and a direction. The block opens the row, issues one READ or WRITE per clock on consecutive columns, and closes the row when the burst ends. It drives the command lines, a multiplexed 13-bit address bus and a 32-bit data bus. Write data is taken from the requester one beat per command. Read data comes back to the requester in address order.

A burst may run past the last column of the open row. The requester does not have to split it. The block closes the row, opens the next row, and resumes at column 0 without losing a beat. At such a break it adds one cycle to each of the precharge-to-activate and activate-to-command gaps. The block does not handle power-up initialisation, refresh, mode-register setup, several open banks or byte masks.

Parameters and their limits: ROW_COLS is a power of two of at most 1024. T_RCD is at least 2. T_RP and CAS_LAT are each at least 1.

Top module: `sdram_burst_seq`

## Requirements
- R1: During and after reset the block is idle. `reqReady` is 1, the command lines carry NOP (`{sdCsN,sdRasN,sdCasN,sdWeN}` = 0111), and `done`, `rdValid` and `sdDqOe` are 0. Whenever `reqReady` is 1 the command is NOP.
- R2: A request is accepted on a clock edge where both `reqValid` and `reqReady` are 1. In the next cycle the block issues ACTIVE with `sdAddr` equal to the requested row. `reqReady` then stays 0 until the cycle after `done`.
- R3: The first READ or WRITE of a burst comes exactly T_RCD cycles after its ACTIVE.
- R4: Column commands are issued one per cycle on consecutive columns. The column appears on `sdAddr[COL_W-1:0]`, and `sdAddr[10]` is 0 (no auto-precharge).
- R5: After a command on the last column (ROW_COLS-1), if beats remain, the next cycle carries PRECHARGE with `sdAddr[10]` = 0. ACTIVE for row+1 follows exactly T_RP+1 cycles after that PRECHARGE. The row wraps from 8191 to 0.
- R6: After the ACTIVE of a row break, the burst resumes at column 0 exactly T_RCD+1 cycles after that ACTIVE.
- R7: Command codes on `{sdCsN,sdRasN,sdCasN,sdWeN}`: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010. A read burst issues only READ and a write burst only WRITE.
- R8: Exactly `reqBeats` column commands are issued. PRECHARGE follows the last one in the next cycle. `done` is high for one cycle, CAS_LAT+1 cycles after that PRECHARGE. `reqReady` is 1 in the cycle after `done`.
- R9: For every READ issued in cycle t, `rdValid` is high in cycle t+CAS_LAT+1. `rdData` then holds the value of `sdDqIn` from cycle t+CAS_LAT. Beats arrive in address order.
- R10: In a WRITE cycle, `sdDqOe` and `wrAccept` are 1 and `sdDqOut` equals `wrData`. In every other cycle, including all read cycles, `sdDqOe` is 0.
- R11: Every cycle of an inserted gap carries NOP. So do the cycles directly after ACTIVE and after PRECHARGE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, shared with the SDRAM |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Burst request present |
| reqReady | output | 1 | Block idle, can take a request |
| reqWrite | input | 1 | 1 = write burst, 0 = read burst |
| reqRow | input | ADDR_W | Start row |
| reqCol | input | COL_W | Start column |
| reqBeats | input | BEAT_W | Beat count, nonzero |
| wrData | input | DATA_W | Write data for the current beat |
| wrAccept | output | 1 | Current `wrData` is consumed this cycle |
| rdValid | output | 1 | `rdData` holds a read beat |
| rdData | output | DATA_W | Read beat |
| done | output | 1 | One-cycle pulse at burst completion |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdAddr | output | ADDR_W | Multiplexed row/column address |
| sdDqOut | output | DATA_W | Data bus, outgoing value |
| sdDqOe | output | 1 | Data bus output enable |
| sdDqIn | input | DATA_W | Data bus, incoming value |

## Verification
Every result has a fixed due cycle, counted from the ACTIVE cycle that follows acceptance:
- The first column command is due T_RCD cycles after that ACTIVE.
- At a row break, ACTIVE is due T_RP+1 cycles after PRECHARGE, and the resumed command T_RCD+1 cycles after that ACTIVE.
- Each read beat is due CAS_LAT+1 cycles after its READ.
- `done` is due CAS_LAT+1 cycles after the closing PRECHARGE.

The bench samples on the falling edge and numbers each cycle from acceptance. It records the cycle of every command and checks each gap against these arithmetic values. A bus model returns row/column-coded read data, so a wrong row or column shows up as a data mismatch.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010
  } sdCmd_t;

  typedef enum logic [1:0] {
    ADDR_ZERO,
    ADDR_ROW,
    ADDR_COL
  } addrSel_t;

  typedef struct packed {
    logic     load;
    logic     advance;
    logic     rdIssue;
    logic     wrDrive;
    addrSel_t addrSel;
  } dpStrobe_t;

  typedef struct packed {
    logic lastBeat;
    logic rowEnd;
    logic isWrite;
  } dpStatus_t;

endpackage

// File: rtl/sdb_ctrl.sv
module sdb_ctrl
  import sdb_pkg::*;
#(
  parameter int T_RP    = 3,
  parameter int T_RCD   = 3,
  parameter int CAS_LAT = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      reqValid,
  input  dpStatus_t status,
  output logic      reqReady,
  output logic      done,
  output sdCmd_t    cmd,
  output dpStrobe_t strobe
);

  localparam int MAX_A   = (T_RP > T_RCD) ? T_RP : T_RCD;
  localparam int MAX_GAP = (MAX_A > CAS_LAT) ? MAX_A : CAS_LAT;
  localparam int CNT_W   = $clog2(MAX_GAP + 2);

  typedef enum logic [2:0] {
    S_IDLE, S_ACT, S_TRCD, S_RW, S_PRE, S_TRP, S_DRAIN, S_DONE
  } state_t;

  state_t            state, stateNext;
  logic [CNT_W-1:0]  gapCnt, gapCntNext;
  logic              breakQ, breakNext;
  logic              finalQ, finalNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      gapCnt <= '0;
      breakQ <= 1'b0;
      finalQ <= 1'b0;
    end else begin
      state  <= stateNext;
      gapCnt <= gapCntNext;
      breakQ <= breakNext;
      finalQ <= finalNext;
    end
  end

  always_comb begin
    stateNext  = state;
    gapCntNext = gapCnt;
    breakNext  = breakQ;
    finalNext  = finalQ;
    strobe     = '0;
    strobe.addrSel = ADDR_ZERO;
    cmd        = CMD_NOP;
    reqReady   = 1'b0;
    done       = 1'b0;
    case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.load = 1'b1;
          breakNext   = 1'b0;
          finalNext   = 1'b0;
          stateNext   = S_ACT;
        end
      end
      S_ACT: begin
        cmd            = CMD_ACT;
        strobe.addrSel = ADDR_ROW;
        gapCntNext     = breakQ ? CNT_W'(T_RCD) : CNT_W'(T_RCD - 1);
        stateNext      = S_TRCD;
      end
      S_TRCD: begin
        gapCntNext = gapCnt - 1'b1;
        if (gapCnt == CNT_W'(1)) stateNext = S_RW;
      end
      S_RW: begin
        cmd            = status.isWrite ? CMD_WR : CMD_RD;
        strobe.addrSel = ADDR_COL;
        strobe.advance = 1'b1;
        strobe.rdIssue = !status.isWrite;
        strobe.wrDrive = status.isWrite;
        if (status.lastBeat) begin
          finalNext = 1'b1;
          stateNext = S_PRE;
        end else if (status.rowEnd) begin
          finalNext = 1'b0;
          stateNext = S_PRE;
        end
      end
      S_PRE: begin
        cmd = CMD_PRE;
        if (finalQ) begin
          gapCntNext = CNT_W'(CAS_LAT);
          stateNext  = S_DRAIN;
        end else begin
          gapCntNext = CNT_W'(T_RP);
          breakNext  = 1'b1;
          stateNext  = S_TRP;
        end
      end
      S_TRP: begin
        gapCntNext = gapCnt - 1'b1;
        if (gapCnt == CNT_W'(1)) stateNext = S_ACT;
      end
      S_DRAIN: begin
        gapCntNext = gapCnt - 1'b1;
        if (gapCnt == CNT_W'(1)) stateNext = S_DONE;
      end
      S_DONE: begin
        done      = 1'b1;
        stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

endmodule

// File: rtl/sdb_datapath.sv
module sdb_datapath
  import sdb_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 32,
  parameter int ROW_COLS = 512,
  parameter int BEAT_W   = 8,
  parameter int CAS_LAT  = 2,
  localparam int COL_W   = $clog2(ROW_COLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [BEAT_W-1:0] reqBeats,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] sdDqIn,
  output dpStatus_t         status,
  output logic [ADDR_W-1:0] sdAddr,
  output logic [DATA_W-1:0] sdDqOut,
  output logic              sdDqOe,
  output logic              wrAccept,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  localparam logic [COL_W-1:0] LAST_COL = COL_W'(ROW_COLS - 1);

  logic [ADDR_W-1:0] rowQ;
  logic [COL_W-1:0]  colQ;
  logic [BEAT_W-1:0] beatsLeft;
  logic              isWriteQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      rowQ      <= '0;
      colQ      <= '0;
      beatsLeft <= '0;
      isWriteQ  <= 1'b0;
    end else if (strobe.load) begin
      rowQ      <= reqRow;
      colQ      <= reqCol;
      beatsLeft <= reqBeats;
      isWriteQ  <= reqWrite;
    end else if (strobe.advance) begin
      colQ      <= colQ + 1'b1;
      beatsLeft <= beatsLeft - 1'b1;
      if (colQ == LAST_COL) rowQ <= rowQ + 1'b1;
    end
  end

  assign status.lastBeat = (beatsLeft == BEAT_W'(1));
  assign status.rowEnd   = (colQ == LAST_COL);
  assign status.isWrite  = isWriteQ;

  always_comb begin
    case (strobe.addrSel)
      ADDR_ROW: sdAddr = rowQ;
      ADDR_COL: sdAddr = ADDR_W'(colQ);
      default:  sdAddr = '0;
    endcase
  end

  assign sdDqOe   = strobe.wrDrive;
  assign wrAccept = strobe.wrDrive;
  assign sdDqOut  = strobe.wrDrive ? wrData : '0;

  logic [CAS_LAT-1:0] rdPipe;

  generate
    if (CAS_LAT == 1) begin : g_pipe1
      always_ff @(posedge clk) begin
        if (rst) rdPipe <= '0;
        else     rdPipe <= strobe.rdIssue;
      end
    end else begin : g_pipeN
      always_ff @(posedge clk) begin
        if (rst) rdPipe <= '0;
        else     rdPipe <= {rdPipe[CAS_LAT-2:0], strobe.rdIssue};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= rdPipe[CAS_LAT-1];
      if (rdPipe[CAS_LAT-1]) rdData <= sdDqIn;
    end
  end

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdb_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 32,
  parameter int ROW_COLS = 512,
  parameter int BEAT_W   = 8,
  parameter int T_RP     = 3,
  parameter int T_RCD    = 3,
  parameter int CAS_LAT  = 2,
  localparam int COL_W   = $clog2(ROW_COLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [BEAT_W-1:0] reqBeats,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrAccept,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [ADDR_W-1:0] sdAddr,
  output logic [DATA_W-1:0] sdDqOut,
  output logic              sdDqOe,
  input  logic [DATA_W-1:0] sdDqIn
);

  dpStrobe_t strobe;
  dpStatus_t status;
  sdCmd_t    cmd;

  sdb_ctrl #(.T_RP(T_RP), .T_RCD(T_RCD), .CAS_LAT(CAS_LAT)) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .status(status),
    .reqReady(reqReady), .done(done), .cmd(cmd), .strobe(strobe)
  );

  sdb_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_COLS(ROW_COLS),
    .BEAT_W(BEAT_W), .CAS_LAT(CAS_LAT)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .reqRow(reqRow), .reqCol(reqCol),
    .reqBeats(reqBeats), .reqWrite(reqWrite), .wrData(wrData), .sdDqIn(sdDqIn),
    .status(status), .sdAddr(sdAddr), .sdDqOut(sdDqOut), .sdDqOe(sdDqOe),
    .wrAccept(wrAccept), .rdValid(rdValid), .rdData(rdData)
  );

  assign {sdCsN, sdRasN, sdCasN, sdWeN} = cmd;

endmodule

// File: rtl/sdram_burst_seq_chk.sv
module sdram_burst_seq_chk
  import sdb_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int COL_W  = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqRow,
  input logic              done,
  input logic              sdCsN,
  input logic              sdRasN,
  input logic              sdCasN,
  input logic              sdWeN,
  input logic [ADDR_W-1:0] sdAddr,
  input logic              sdDqOe,
  input logic              wrAccept
);

  logic [3:0] pinCmd;
  logic       colCmd;
  assign pinCmd = {sdCsN, sdRasN, sdCasN, sdWeN};
  assign colCmd = (pinCmd == CMD_RD) || (pinCmd == CMD_WR);

  AST_IDLE_NOP: assert property (@(posedge clk) disable iff (rst)
    reqReady |-> pinCmd == CMD_NOP);  // R1
  AST_ACCEPT_ACT: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady) |=> (pinCmd == CMD_ACT && sdAddr == $past(reqRow) && !reqReady));  // R2
  AST_COL_STEP: assert property (@(posedge clk) disable iff (rst)
    (colCmd && $past(colCmd)) |-> sdAddr[COL_W-1:0] == COL_W'($past(sdAddr[COL_W-1:0]) + 1'b1));  // R4
  AST_NO_AUTOPRE: assert property (@(posedge clk) disable iff (rst)
    (colCmd || pinCmd == CMD_PRE) |-> !sdAddr[10]);  // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && reqReady));  // R8
  AST_ACT_GAP_NOP: assert property (@(posedge clk) disable iff (rst)
    (pinCmd == CMD_ACT) |=> pinCmd == CMD_NOP);  // R11
  AST_PRE_GAP_NOP: assert property (@(posedge clk) disable iff (rst)
    (pinCmd == CMD_PRE) |=> pinCmd == CMD_NOP);  // R11
  AST_WR_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (pinCmd == CMD_WR) |-> (sdDqOe && wrAccept));  // R10
  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (pinCmd != CMD_WR) |-> !sdDqOe);  // R10

endmodule

bind sdram_burst_seq sdram_burst_seq_chk #(.ADDR_W(ADDR_W), .COL_W($clog2(ROW_COLS))) u_chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady), .reqRow(reqRow),
  .done(done), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
  .sdAddr(sdAddr), .sdDqOe(sdDqOe), .wrAccept(wrAccept)
);

// File: tb/sdram_burst_seq_tb.sv
module sdram_burst_seq_tb;

  localparam int ADDR_W = 13;
  localparam int DATA_W = 32;
  localparam int ROWC   = 16;
  localparam int COL_W  = $clog2(ROWC);
  localparam int BEAT_W = 8;
  localparam int TRP    = 3;
  localparam int TRCD   = 3;
  localparam int CL     = 2;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_PRE = 4'b0010;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic              reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqRow = '0;
  logic [COL_W-1:0]  reqCol = '0;
  logic [BEAT_W-1:0] reqBeats = '0;
  logic [DATA_W-1:0] wrData;
  logic              wrAccept, rdValid, done;
  logic [DATA_W-1:0] rdData, sdDqOut, sdDqIn;
  logic              sdCsN, sdRasN, sdCasN, sdWeN, sdDqOe;
  logic [ADDR_W-1:0] sdAddr;
  logic [3:0]        cmdv;

  int nChecks = 0;
  int nFails  = 0;
  int tick    = 0;

  always #2 clk = ~clk;

  sdram_burst_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_COLS(ROWC), .BEAT_W(BEAT_W),
    .T_RP(TRP), .T_RCD(TRCD), .CAS_LAT(CL)
  ) u_dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqRow(reqRow), .reqCol(reqCol), .reqBeats(reqBeats),
    .wrData(wrData), .wrAccept(wrAccept), .rdValid(rdValid), .rdData(rdData),
    .done(done), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
    .sdAddr(sdAddr), .sdDqOut(sdDqOut), .sdDqOe(sdDqOe), .sdDqIn(sdDqIn)
  );

  assign cmdv = {sdCsN, sdRasN, sdCasN, sdWeN};

  function automatic logic [31:0] rdPat(input int row, input int col);
    return 32'hC000_0000 | (32'(row) << 16) | 32'(col);
  endfunction

  function automatic logic [31:0] wrPat(input int k);
    return 32'h3C5A_0000 ^ (32'(k) * 32'h0101_0101);
  endfunction

  // Write data source: advances on each accepted beat
  int wrIdx = 0;
  always @(posedge clk) begin
    if (rst || (reqValid && reqReady)) wrIdx <= 0;
    else if (wrAccept) wrIdx <= wrIdx + 1;
  end
  assign wrData = wrPat(wrIdx);

  // Bus model: answers READ with row/column-coded data CL cycles later
  int          openRow = 0;
  logic        mv [CL];
  logic [31:0] md [CL];
  always @(posedge clk) begin
    if (cmdv == C_ACT) openRow <= int'(sdAddr);
    mv[0] <= (cmdv == C_RD);
    md[0] <= rdPat(openRow, int'(sdAddr[COL_W-1:0]));
    for (int i = 1; i < CL; i++) begin
      mv[i] <= mv[i-1];
      md[i] <= md[i-1];
    end
  end
  assign sdDqIn = mv[CL-1] ? md[CL-1] : 32'hDEAD_BEEF;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runBurst(input int row, input int col, input int beats, input bit wr);
    int cyc, lastAct, lastPre, lastRw, finalPre, issued, rdSeen, gapExp;
    int expRow, expCol, r, c;
    bit needGap, seenDone;
    int rwCyc [256];
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqRow = ADDR_W'(row); reqCol = COL_W'(col);
    reqBeats = BEAT_W'(beats); reqWrite = wr;
    @(negedge clk);
    reqValid = 1'b0;
    cyc = 0; lastAct = -100; lastPre = -100; lastRw = -100; finalPre = -100;
    issued = 0; rdSeen = 0; gapExp = TRCD; needGap = 1'b1; seenDone = 1'b0;
    expRow = row; expCol = col;
    while (!seenDone && cyc < 1000) begin
      case (cmdv)
        C_ACT: begin
          if (cyc == 0) check(sdAddr == ADDR_W'(row), "R2 act row", sdAddr, row);
          else check(cyc - lastPre == TRP + 1, "R5 pre-to-act gap", cyc - lastPre, TRP + 1);
          check(sdAddr == ADDR_W'(expRow), "R5 row", sdAddr, expRow);
          gapExp = (cyc == 0) ? TRCD : TRCD + 1;
          lastAct = cyc; needGap = 1'b1;
          check(!sdDqOe, "R10 oe", sdDqOe, 0);
        end
        C_RD, C_WR: begin
          check(cmdv == (wr ? C_WR : C_RD), "R7 cmd code", cmdv, wr ? C_WR : C_RD);
          if (needGap) begin
            if (gapExp == TRCD) check(cyc - lastAct == gapExp, "R3 act-to-cmd", cyc - lastAct, gapExp);
            else check(cyc - lastAct == gapExp, "R6 break act-to-cmd", cyc - lastAct, gapExp);
          end else check(cyc == lastRw + 1, "R4 back-to-back", cyc, lastRw + 1);
          check(sdAddr == ADDR_W'(expCol), "R4 column", sdAddr, expCol);
          if (wr) check(sdDqOe && wrAccept && sdDqOut == wrPat(issued), "R10 write data", sdDqOut, wrPat(issued));
          else check(!sdDqOe && !wrAccept, "R10 read bus off", sdDqOe, 0);
          if (issued < 256) rwCyc[issued] = cyc;
          needGap = 1'b0; lastRw = cyc; issued++; expCol++;
          if (expCol == ROWC) begin expCol = 0; expRow = (expRow + 1) % 8192; end
        end
        C_PRE: begin
          check(cyc == lastRw + 1, "R5 R8 pre follows cmd", cyc, lastRw + 1);
          check(!sdAddr[10], "R5 single-bank pre", sdAddr[10], 0);
          if (issued == beats) finalPre = cyc;
          else check(expCol == 0, "R5 break only at row end", expCol, 0);
          lastPre = cyc;
          check(!sdDqOe, "R10 oe", sdDqOe, 0);
        end
        C_NOP: check(!sdDqOe, "R11 gap nop bus off", sdDqOe, 0);
        default: check(1'b0, "R7 illegal command", cmdv, C_NOP);
      endcase
      if (rdValid) begin
        r = (row + (col + rdSeen) / ROWC) % 8192;
        c = (col + rdSeen) % ROWC;
        check(!wr && rdData == rdPat(r, c), "R9 read data", rdData, rdPat(r, c));
        if (rdSeen < 256)
          check(cyc == rwCyc[rdSeen] + CL + 1, "R9 read latency", cyc - rwCyc[rdSeen], CL + 1);
        rdSeen++;
      end
      if (done) begin
        check(cyc == finalPre + CL + 1, "R8 done timing", cyc - finalPre, CL + 1);
        check(issued == beats, "R8 beat count", issued, beats);
        check(rdSeen == (wr ? 0 : beats), "R9 read count", rdSeen, wr ? 0 : beats);
        seenDone = 1'b1;
      end else begin
        check(!reqReady, "R2 busy", reqReady, 0);
      end
      @(negedge clk);
      cyc++;
    end
    if (!seenDone) check(1'b0, "R8 done missing", 0, 1);
    check(reqReady && cmdv == C_NOP, "R8 ready after done", {reqReady, cmdv}, {1'b1, C_NOP});
  endtask

  always @(negedge clk) begin
    tick++;
    if (tick > 190000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected<=%0d", tick, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int beatList [6] = '{1, 2, 7, 16, 17, 33};
    repeat (4) @(negedge clk);
    check(reqReady && cmdv == C_NOP && !done && !sdDqOe && !rdValid, "R1 in reset",
          {reqReady, cmdv, done, sdDqOe, rdValid}, {1'b1, C_NOP, 3'b000});
    rst = 1'b0;
    @(negedge clk);
    check(reqReady && cmdv == C_NOP && !done && !sdDqOe && !rdValid, "R1 after reset",
          {reqReady, cmdv, done, sdDqOe, rdValid}, {1'b1, C_NOP, 3'b000});
    for (int wr = 0; wr < 2; wr++)
      for (int col = 0; col < ROWC; col++)
        for (int b = 0; b < 6; b++)
          runBurst((col * 523 + beatList[b] * 7 + wr) % 8192, col, beatList[b], wr[0]);
    runBurst(8191, 14, 5, 1'b0);
    runBurst(8191, 13, 40, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

endmodule